// File: doc/BRIEF.md
# Block Copy DMA Channel

This block is one DMA channel that copies a block of bytes from a 64-bit addressed DRAM space into a smaller internal SRAM. Software programs a destination SRAM address, a 64-bit source DRAM address and a length in bytes through a small register port. It then writes the control register with the launch bit set. The channel moves the block one 32-bit word at a time. For each word it issues a read request toward DRAM, waits for the returned data, then issues a write request toward SRAM with byte enables.

The length need not be a multiple of four. The final word carries only as many byte enables as there are bytes left. A stored snoop attribute bit accompanies every request on both memory ports. A two-bit target field decides whether completion raises a one-cycle interrupt pulse.

An idle flag is visible as a port and through a status register. It drops as soon as a launch is accepted and rises again when the copy ends. At that point the launch bit also reads back as zero. Register writes arriving while a copy is running are discarded.

Top module: `svc_dma_chan`

## Requirements
- R1: After reset the channel is idle (`chan_idle`=1), `done_irq` is 0, neither memory request is asserted, and every register reads 0 except the status register, which reads 1 in bit 0.
- R2: Register select 1 holds the SRAM byte address, 2 the low 32 bits of the DRAM address, 3 the high 32 bits, and 4 the byte count. Select 0 is control: bit 0 is snoop, bits 25:24 are the interrupt target, and bit 31 is the launch bit. Select 5 is status, with bit 0 idle. Written values read back unchanged, and control bit 31 reads 1 only while a copy is running.
- R3: Writing select 0 with bit 31 set while idle launches a copy, and `chan_idle` is 0 in the very next cycle.
- R4: Word k of a copy reads DRAM at the programmed 64-bit address plus 4k and writes the returned data to SRAM at the programmed address plus 4k. Reads and writes alternate and never overlap.
- R5: A copy of N bytes performs ceil(N/4) word reads and writes. Every write has all four byte enables set, except that the last one enables only the low N mod 4 lanes when N mod 4 is nonzero.
- R6: `dram_rd_snoop` and `sram_wr_snoop` equal control bit 0 on every request.
- R7: When the last write is granted, the channel spends one cycle in a done state and then returns to idle, with the launch bit reading 0. During the done cycle `done_irq` is 1 exactly when control bits 25:24 equal 1.
- R8: Register writes of any select made while a copy is running are ignored. They neither change readback nor affect the copy in progress.
- R9: A launch with a byte count of 0 performs no memory request. The done cycle follows the launch write directly, so `chan_idle` is 0 and `done_irq` follows R7 for one cycle, after which the channel is idle.
- R10: A request that is not granted stays asserted, with address, data and byte enables held stable, until its grant arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| dram_rd_req | output | 1 | DRAM word read request |
| dram_rd_addr | output | 64 | DRAM read byte address |
| dram_rd_snoop | output | 1 | Snoop attribute for the read |
| dram_rd_gnt | input | 1 | Read request accepted this cycle |
| dram_rd_valid | input | 1 | Read data returned this cycle |
| dram_rd_data | input | 32 | Read data |
| sram_wr_req | output | 1 | SRAM word write request |
| sram_wr_addr | output | SRAM_AW | SRAM write byte address |
| sram_wr_data | output | 32 | SRAM write data |
| sram_wr_be | output | 4 | SRAM byte enables |
| sram_wr_snoop | output | 1 | Snoop attribute for the write |
| sram_wr_gnt | input | 1 | Write request accepted this cycle |
| chan_idle | output | 1 | No copy active |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
A launch write takes effect at the clock edge that samples it. The bench therefore checks `chan_idle` at the falling edge right after that write. For a zero-length launch it checks `done_irq` at that same falling edge and idle one cycle later. Each word takes three cycles when nothing stalls: request, data return on the cycle after the read grant, and the write request on the cycle after that. The bench's memory model grants and answers at falling edges, when the request outputs are settled. It checks the addresses, snoop and byte enables of each request as it is granted. Completion checks wait for idle, then inspect the SRAM model, the interrupt pulse count and the launch-bit readback.

// File: rtl/svc_dma_pkg.sv
package svc_dma_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_SRAM    = 3'd1,
        SEL_DRAM_LO = 3'd2,
        SEL_DRAM_HI = 3'd3,
        SEL_COUNT   = 3'd4,
        SEL_STATUS  = 3'd5
    } reg_sel_e;

    localparam int CTRL_GO_BIT    = 31;
    localparam int CTRL_TGT_LSB   = 24;
    localparam int CTRL_SNOOP_BIT = 0;

    localparam logic [1:0] TGT_HOST = 2'd1;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_WAIT,
        ENG_STORE,
        ENG_DONE
    } eng_state_e;

    typedef struct packed {
        logic [1:0] target;
        logic       snoop;
    } ctrl_attr_t;

endpackage

// File: rtl/svc_dma_regs.sv
module svc_dma_regs
    import svc_dma_pkg::*;
#(
    parameter int SRAM_AW = 16,
    parameter int CNT_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output logic [WORD_W-1:0]   cfg_rdata,
    input  logic                eng_idle,
    output logic                launch,
    output ctrl_attr_t          attr,
    output logic [SRAM_AW-1:0]  sram_base,
    output logic [63:0]         dram_base,
    output logic [CNT_W-1:0]    byte_count
);

    reg_sel_e sel;
    logic     wr_ok;

    assign sel    = reg_sel_e'(cfg_sel);
    assign wr_ok  = cfg_we && eng_idle;
    assign launch = wr_ok && (sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            attr       <= '0;
            sram_base  <= '0;
            dram_base  <= '0;
            byte_count <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_CTRL: begin
                    attr.snoop  <= cfg_wdata[CTRL_SNOOP_BIT];
                    attr.target <= cfg_wdata[CTRL_TGT_LSB +: 2];
                end
                SEL_SRAM:    sram_base        <= cfg_wdata[SRAM_AW-1:0];
                SEL_DRAM_LO: dram_base[31:0]  <= cfg_wdata;
                SEL_DRAM_HI: dram_base[63:32] <= cfg_wdata;
                SEL_COUNT:   byte_count       <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                cfg_rdata[CTRL_GO_BIT]         = !eng_idle;
                cfg_rdata[CTRL_TGT_LSB +: 2]   = attr.target;
                cfg_rdata[CTRL_SNOOP_BIT]      = attr.snoop;
            end
            SEL_SRAM:    cfg_rdata = WORD_W'(sram_base);
            SEL_DRAM_LO: cfg_rdata = dram_base[31:0];
            SEL_DRAM_HI: cfg_rdata = dram_base[63:32];
            SEL_COUNT:   cfg_rdata = WORD_W'(byte_count);
            SEL_STATUS:  cfg_rdata[0] = eng_idle;
            default:     cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/svc_dma_engine.sv
module svc_dma_engine
    import svc_dma_pkg::*;
#(
    parameter int SRAM_AW = 16,
    parameter int CNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  logic [SRAM_AW-1:0]   sram_base,
    input  logic [63:0]          dram_base,
    input  logic [CNT_W-1:0]     byte_count,
    output logic                 rd_req,
    output logic [63:0]          rd_addr,
    input  logic                 rd_gnt,
    input  logic                 rd_valid,
    input  logic [WORD_W-1:0]    rd_data,
    output logic                 wr_req,
    output logic [SRAM_AW-1:0]   wr_addr,
    output logic [WORD_W-1:0]    wr_data,
    output logic [WORD_BYTES-1:0] wr_be,
    input  logic                 wr_gnt,
    output logic                 eng_idle,
    output logic                 eng_done
);

    localparam logic [CNT_W-1:0]   STEP_CNT  = CNT_W'(WORD_BYTES);
    localparam logic [63:0]        STEP_DRAM = 64'(WORD_BYTES);
    localparam logic [SRAM_AW-1:0] STEP_SRAM = SRAM_AW'(WORD_BYTES);

    eng_state_e         state;
    logic [CNT_W-1:0]   remain;
    logic [63:0]        dptr;
    logic [SRAM_AW-1:0] sptr;
    logic [WORD_W-1:0]  hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            remain <= '0;
            dptr   <= '0;
            sptr   <= '0;
            hold   <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (launch) begin
                    remain <= byte_count;
                    dptr   <= dram_base;
                    sptr   <= sram_base;
                    state  <= (byte_count == '0) ? ENG_DONE : ENG_FETCH;
                end
                ENG_FETCH: if (rd_gnt) state <= ENG_WAIT;
                ENG_WAIT: if (rd_valid) begin
                    hold  <= rd_data;
                    state <= ENG_STORE;
                end
                ENG_STORE: if (wr_gnt) begin
                    dptr <= dptr + STEP_DRAM;
                    sptr <= sptr + STEP_SRAM;
                    if (remain <= STEP_CNT) begin
                        remain <= '0;
                        state  <= ENG_DONE;
                    end else begin
                        remain <= remain - STEP_CNT;
                        state  <= ENG_FETCH;
                    end
                end
                ENG_DONE: state <= ENG_IDLE;
                default:  state <= ENG_IDLE;
            endcase
        end
    end

    generate
        for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_lane
            assign wr_be[lane] = (remain > CNT_W'(lane));
        end
    endgenerate

    assign rd_req   = (state == ENG_FETCH);
    assign rd_addr  = dptr;
    assign wr_req   = (state == ENG_STORE);
    assign wr_addr  = sptr;
    assign wr_data  = hold;
    assign eng_idle = (state == ENG_IDLE);
    assign eng_done = (state == ENG_DONE);

endmodule

// File: rtl/svc_dma_chan.sv
module svc_dma_chan
    import svc_dma_pkg::*;
#(
    parameter int SRAM_AW = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic               dram_rd_req,
    output logic [63:0]        dram_rd_addr,
    output logic               dram_rd_snoop,
    input  logic               dram_rd_gnt,
    input  logic               dram_rd_valid,
    input  logic [31:0]        dram_rd_data,
    output logic               sram_wr_req,
    output logic [SRAM_AW-1:0] sram_wr_addr,
    output logic [31:0]        sram_wr_data,
    output logic [3:0]         sram_wr_be,
    output logic               sram_wr_snoop,
    input  logic               sram_wr_gnt,
    output logic               chan_idle,
    output logic               done_irq
);

    logic               launch;
    logic               eng_idle;
    logic               eng_done;
    ctrl_attr_t         attr;
    logic [SRAM_AW-1:0] sram_base;
    logic [63:0]        dram_base;
    logic [CNT_W-1:0]   byte_count;

    svc_dma_regs #(.SRAM_AW(SRAM_AW), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .eng_idle   (eng_idle),
        .launch     (launch),
        .attr       (attr),
        .sram_base  (sram_base),
        .dram_base  (dram_base),
        .byte_count (byte_count)
    );

    svc_dma_engine #(.SRAM_AW(SRAM_AW), .CNT_W(CNT_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .sram_base  (sram_base),
        .dram_base  (dram_base),
        .byte_count (byte_count),
        .rd_req     (dram_rd_req),
        .rd_addr    (dram_rd_addr),
        .rd_gnt     (dram_rd_gnt),
        .rd_valid   (dram_rd_valid),
        .rd_data    (dram_rd_data),
        .wr_req     (sram_wr_req),
        .wr_addr    (sram_wr_addr),
        .wr_data    (sram_wr_data),
        .wr_be      (sram_wr_be),
        .wr_gnt     (sram_wr_gnt),
        .eng_idle   (eng_idle),
        .eng_done   (eng_done)
    );

    assign dram_rd_snoop = attr.snoop;
    assign sram_wr_snoop = attr.snoop;
    assign chan_idle     = eng_idle;
    assign done_irq      = eng_done && (attr.target == TGT_HOST);

endmodule

// File: rtl/svc_dma_chk.sv
module svc_dma_chk #(
    parameter int SRAM_AW = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic               chan_idle,
    input logic               done_irq,
    input logic               dram_rd_req,
    input logic               dram_rd_gnt,
    input logic [63:0]        dram_rd_addr,
    input logic               sram_wr_req,
    input logic               sram_wr_gnt,
    input logic [SRAM_AW-1:0] sram_wr_addr,
    input logic [31:0]        sram_wr_data,
    input logic [3:0]         sram_wr_be
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        chan_idle |-> (!dram_rd_req && !sram_wr_req)); // R3

    AST_IDLE_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_idle) |-> $past(cfg_we)); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(dram_rd_req && sram_wr_req)); // R4

    AST_BE_CONTIG: assert property (@(posedge clk) disable iff (rst)
        sram_wr_req |-> (sram_wr_be[0] && ((sram_wr_be & (sram_wr_be + 4'd1)) == 4'd0))); // R5

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> (!done_irq && chan_idle)); // R7

    AST_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> !chan_idle); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dram_rd_req && !dram_rd_gnt) |=> (dram_rd_req && $stable(dram_rd_addr))); // R10

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sram_wr_req && !sram_wr_gnt) |=>
        (sram_wr_req && $stable(sram_wr_addr) && $stable(sram_wr_data) && $stable(sram_wr_be))); // R10

endmodule

bind svc_dma_chan svc_dma_chk #(.SRAM_AW(SRAM_AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .chan_idle    (chan_idle),
    .done_irq     (done_irq),
    .dram_rd_req  (dram_rd_req),
    .dram_rd_gnt  (dram_rd_gnt),
    .dram_rd_addr (dram_rd_addr),
    .sram_wr_req  (sram_wr_req),
    .sram_wr_gnt  (sram_wr_gnt),
    .sram_wr_addr (sram_wr_addr),
    .sram_wr_data (sram_wr_data),
    .sram_wr_be   (sram_wr_be)
);

// File: tb/sim_svc_dma_chan.sv
`timescale 1ns/1ps
module sim_svc_dma_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dram_rd_req;
    logic [63:0] dram_rd_addr;
    logic        dram_rd_snoop;
    logic        dram_rd_gnt = 1'b0;
    logic        dram_rd_valid = 1'b0;
    logic [31:0] dram_rd_data = '0;
    logic        sram_wr_req;
    logic [15:0] sram_wr_addr;
    logic [31:0] sram_wr_data;
    logic [3:0]  sram_wr_be;
    logic        sram_wr_snoop;
    logic        sram_wr_gnt = 1'b0;
    logic        chan_idle;
    logic        done_irq;

    always #2.5 clk = ~clk;

    svc_dma_chan u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dram_rd_req(dram_rd_req), .dram_rd_addr(dram_rd_addr), .dram_rd_snoop(dram_rd_snoop),
        .dram_rd_gnt(dram_rd_gnt), .dram_rd_valid(dram_rd_valid), .dram_rd_data(dram_rd_data),
        .sram_wr_req(sram_wr_req), .sram_wr_addr(sram_wr_addr), .sram_wr_data(sram_wr_data),
        .sram_wr_be(sram_wr_be), .sram_wr_snoop(sram_wr_snoop), .sram_wr_gnt(sram_wr_gnt),
        .chan_idle(chan_idle), .done_irq(done_irq)
    );

    int n_cmp  = 0;
    int n_bad  = 0;

    // memory model state
    logic [7:0]  mem [0:255];
    logic        stall_en   = 1'b0;
    logic        exp_snoop  = 1'b0;
    logic [63:0] exp_dbase  = '0;
    logic [15:0] exp_sbase  = '0;
    int          rd_cnt     = 0;
    int          wr_cnt     = 0;
    int          addr_err   = 0;
    int          snoop_err  = 0;
    int          irq_cnt    = 0;
    logic [3:0]  last_be    = '0;
    int          cyc        = 0;
    logic        rd_pend    = 1'b0;
    logic [63:0] pend_addr  = '0;

    function automatic logic [31:0] pat(input logic [63:0] a);
        return (a[31:0] * 32'h9E3779B1) ^ a[63:32] ^ 32'h5A5A0000;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // responder and monitor, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            dram_rd_valid = 1'b0;
            if (rd_pend) begin
                dram_rd_valid = 1'b1;
                dram_rd_data  = pat(pend_addr);
                rd_pend       = 1'b0;
            end
            if (dram_rd_req && (!stall_en || (cyc % 3 == 2))) begin
                dram_rd_gnt = 1'b1;
                if (dram_rd_addr != exp_dbase + 64'(4 * rd_cnt)) addr_err++;
                if (dram_rd_snoop != exp_snoop) snoop_err++;
                rd_cnt++;
                rd_pend   = 1'b1;
                pend_addr = dram_rd_addr;
            end else begin
                dram_rd_gnt = 1'b0;
            end
            if (sram_wr_req && (!stall_en || (cyc % 3 == 1))) begin
                sram_wr_gnt = 1'b1;
                if (sram_wr_addr != exp_sbase + 16'(4 * wr_cnt)) addr_err++;
                if (sram_wr_snoop != exp_snoop) snoop_err++;
                for (int b = 0; b < 4; b++)
                    if (sram_wr_be[b]) mem[8'(sram_wr_addr) + 8'(b)] = sram_wr_data[8*b +: 8];
                last_be = sram_wr_be;
                wr_cnt++;
            end else begin
                sram_wr_gnt = 1'b0;
            end
            if (done_irq) irq_cnt++;
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [31:0] data);
        cfg_sel = sel;
        #1;
        data = cfg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (!chan_idle && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(chan_idle, tag, 64'(chan_idle), 64'd1);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        chk(chan_idle == 1'b1, "R1 idle", 64'(chan_idle), 64'd1);
        chk(done_irq == 1'b0, "R1 irq", 64'(done_irq), 64'd0);
        chk(!dram_rd_req && !sram_wr_req, "R1 req", 64'({dram_rd_req, sram_wr_req}), 64'd0);
        for (int s = 0; s < 5; s++) begin
            cfg_read(3'(s), v);
            chk(v == 32'd0, "R1 reg", 64'(v), 64'd0);
        end
        cfg_read(3'd5, v);
        chk(v == 32'd1, "R1 status", 64'(v), 64'd1);
    endtask

    task automatic test_readback();
        logic [31:0] v;
        cfg_write(3'd1, 32'h0000_1234);
        cfg_write(3'd2, 32'hCAFE_0040);
        cfg_write(3'd3, 32'h0000_00AB);
        cfg_write(3'd4, 32'h0000_0155);
        cfg_write(3'd0, 32'h0200_0001);
        cfg_read(3'd1, v); chk(v == 32'h1234, "R2 sram", 64'(v), 64'h1234);
        cfg_read(3'd2, v); chk(v == 32'hCAFE_0040, "R2 dram lo", 64'(v), 64'hCAFE0040);
        cfg_read(3'd3, v); chk(v == 32'hAB, "R2 dram hi", 64'(v), 64'hAB);
        cfg_read(3'd4, v); chk(v == 32'h155, "R2 count", 64'(v), 64'h155);
        cfg_read(3'd0, v); chk(v == 32'h0200_0001, "R2 ctrl", 64'(v), 64'h02000001);
        chk(chan_idle, "R2 no launch", 64'(chan_idle), 64'd1);
    endtask

    // one complete copy with checks; poke=1 writes registers while busy (R8)
    task automatic run_copy(input logic [15:0] sb, input logic [63:0] db, input int cnt,
                            input logic snp, input logic [1:0] tgt, input logic stall,
                            input logic poke, input string tag);
        int words;
        int irq0;
        int mism;
        logic [31:0] v;
        logic [3:0]  exp_be;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        words = (cnt + 3) / 4;
        stall_en = stall; exp_snoop = snp; exp_dbase = db; exp_sbase = sb;
        rd_cnt = 0; wr_cnt = 0; addr_err = 0; snoop_err = 0;
        cfg_write(3'd1, 32'(sb));
        cfg_write(3'd2, db[31:0]);
        cfg_write(3'd3, db[63:32]);
        cfg_write(3'd4, 32'(cnt));
        irq0 = irq_cnt;
        cfg_write(3'd0, 32'h8000_0000 | (32'(tgt) << 24) | 32'(snp));
        chk(!chan_idle, {tag, " R3 idle drops"}, 64'(chan_idle), 64'd0);
        cfg_read(3'd0, v);
        chk(v[31], {tag, " R2 go reads busy"}, 64'(v[31]), 64'd1);
        if (poke) begin
            cfg_write(3'd1, 32'h0000_0080);
            cfg_write(3'd4, 32'd40);
            cfg_write(3'd2, 32'h0000_9000);
            cfg_read(3'd1, v);
            chk(v == 32'(sb), {tag, " R8 sram kept"}, 64'(v), 64'(sb));
            cfg_read(3'd4, v);
            chk(v == 32'(cnt), {tag, " R8 count kept"}, 64'(v), 64'(cnt));
        end
        wait_idle({tag, " R7 back to idle"});
        chk(rd_cnt == words && wr_cnt == words, {tag, " R5 word count"},
            64'(wr_cnt), 64'(words));
        chk(addr_err == 0, {tag, " R4 addresses"}, 64'(addr_err), 64'd0);
        chk(snoop_err == 0, {tag, " R6 snoop"}, 64'(snoop_err), 64'd0);
        exp_be = (cnt % 4 == 0) ? 4'hF : 4'((1 << (cnt % 4)) - 1);
        chk(last_be == exp_be, {tag, " R5 last be"}, 64'(last_be), 64'(exp_be));
        mism = 0;
        for (int j = 0; j < words * 4; j++) begin
            logic [31:0] w;
            logic [7:0]  e;
            w = pat(db + 64'(4 * (j / 4)));
            e = (j < cnt) ? w[8 * (j % 4) +: 8] : 8'h00;
            if (mem[8'(sb) + 8'(j)] != e) mism++;
        end
        chk(mism == 0, {tag, " R4 R10 data"}, 64'(mism), 64'd0);
        chk((irq_cnt - irq0) == ((tgt == 2'd1) ? 1 : 0), {tag, " R7 irq pulses"},
            64'(irq_cnt - irq0), 64'((tgt == 2'd1) ? 1 : 0));
        cfg_read(3'd0, v);
        chk(!v[31], {tag, " R7 go cleared"}, 64'(v[31]), 64'd0);
    endtask

    task automatic test_zero(input logic [1:0] tgt, input string tag);
        int irq0;
        rd_cnt = 0; wr_cnt = 0;
        cfg_write(3'd4, 32'd0);
        irq0 = irq_cnt;
        cfg_write(3'd0, 32'h8000_0000 | (32'(tgt) << 24));
        chk(!chan_idle, {tag, " R9 done cycle busy"}, 64'(chan_idle), 64'd0);
        chk(done_irq == (tgt == 2'd1), {tag, " R9 irq in done cycle"},
            64'(done_irq), 64'(tgt == 2'd1));
        @(negedge clk);
        chk(chan_idle && !done_irq, {tag, " R9 idle after"}, 64'({chan_idle, done_irq}), 64'h2);
        chk(rd_cnt == 0 && wr_cnt == 0, {tag, " R9 no access"}, 64'(rd_cnt + wr_cnt), 64'd0);
        chk((irq_cnt - irq0) == ((tgt == 2'd1) ? 1 : 0), {tag, " R9 irq count"},
            64'(irq_cnt - irq0), 64'((tgt == 2'd1) ? 1 : 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_readback();
        run_copy(16'h0010, 64'h0000_0012_3456_7000, 16, 1'b1, 2'd1, 1'b0, 1'b0, "aligned");
        run_copy(16'h0040, 64'h0000_0000_0000_0200, 7, 1'b0, 2'd0, 1'b1, 1'b0, "tail7 stall");
        run_copy(16'h0060, 64'hFFFF_0000_0000_0010, 1, 1'b1, 2'd2, 1'b0, 1'b0, "single byte");
        run_copy(16'h0020, 64'h0000_0001_0000_0100, 10, 1'b0, 2'd1, 1'b1, 1'b1, "busy poke");
        test_zero(2'd1, "zero host");
        test_zero(2'd0, "zero quiet");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule